// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the data side of a multi-cycle processor in which every transfer between storage elements uses one shared 32-bit bus. It contains 33 register slots: 32 general registers and a program-counter slot. It also holds two ALU operand latches (A and B), a memory address register, an instruction register, an ALU and an immediate extender. An external sequencer supplies one control word per clock. The word names at most one bus source, the destinations that capture the bus at the next clock edge, and the operation for the ALU and for the extender.

Memory sits outside the block. The memory address register drives the address. The bus doubles as write data. Read data enters as one of the four bus sources. A busy line from memory is passed back to the sequencer with the zero status of latch A and the opcode field of the instruction register. A sequencer can build every instruction step from these transfers: fetch (MA from PC, IR from memory, A from PC, PC from A plus 4), ALU operations, loads and stores, jumps and zero-tested branches.

Top module: `sbus_datapath`

## Requirements
- R1: The control word `ctl_i` is 18 bits: [17] load IR, [16] load A, [15] load B, [14] load MA, [13] register write, [12] memory write, [11] register-file output enable, [10] memory output enable, [9] ALU output enable, [8] extender output enable, [7:5] register select, [4:2] ALU operation, [1:0] extender mode. The bus carries the enabled source in the same cycle and reads zero when no source is enabled. `mem_wdata_o` always shows the bus.
- R2: At most one output enable may be set per cycle. An enabled register file, memory, ALU or extender each places its own value on the bus. If several are set, the bus takes the lowest-numbered one (register file, then memory, then ALU, then extender) and an assertion reports the conflict.
- R3: Register select codes: 0 addresses IR[25:21], 1 addresses IR[20:16], 2 addresses IR[15:11], 3 addresses register 31, 4 addresses the PC slot (index 32), and 5 to 7 address register 0. A register write stores the bus into the addressed slot at the clock edge.
- R4: Register 0 always reads zero, and writes to it have no effect.
- R5: Latches A, B, MA and IR capture the bus at the clock edge when their load bit is set and otherwise hold. `mem_addr_o` shows MA, and `opcode_o` shows IR[31:26].
- R6: ALU operation codes: 0 A+B, 1 A−B, 2 A AND B, 3 A OR B, 4 A XOR B, 5 signed A<B giving 1 or 0, 6 A+4 (the PC increment, B ignored), 7 B passed through.
- R7: Extender modes: 0 sign-extends IR[15:0], 1 zero-extends IR[15:0], 2 sign-extends IR[25:0], 3 gives zero.
- R8: `zero_o` is 1 exactly when latch A holds zero.
- R9: `mem_we_o` and `mem_re_o` follow the memory write and memory output enable bits in the same cycle, and `busy_o` follows `mem_busy_i` combinationally.
- R10: After reset, every register slot and latch is zero, so `zero_o`=1, `opcode_o`=0, `mem_addr_o`=0 and the PC slot reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_i | input | 18 | Control word for this cycle |
| mem_rdata_i | input | 32 | Memory read data (bus source) |
| mem_busy_i | input | 1 | Memory busy status |
| mem_addr_o | output | 32 | Memory address (MA latch) |
| mem_wdata_o | output | 32 | Memory write data (bus value) |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read enable |
| zero_o | output | 1 | Latch A equals zero |
| opcode_o | output | 6 | IR[31:26] |
| busy_o | output | 1 | Memory busy passed to the sequencer |

## Verification
The bench first runs directed patterns. A fetch sequence shows that the PC slot steps by 4 through the ALU. Writes through the discarded select codes show that register 0 stays zero. One instruction word with both immediate sign bits set separates sign extension from zero extension in each extender mode. A most-negative operand against a small positive one separates signed less-than from unsigned less-than and subtraction from addition. After that, thousands of random control words with one or no driver move random memory words through every latch and register slot. Each bus value is compared against a full-state reference, so a wrong selector decode, a missing hold or a lost write shows up on a later read.

// File: rtl/sbd_pkg.sv
package sbd_pkg;

  localparam int XLEN   = 32;
  localparam int CTLW   = 18;
  localparam int OPW    = 6;
  localparam int RFW    = 5;
  localparam int NDRV   = 4;

  // bus driver indices, lower index wins on conflict
  localparam int DRV_RF  = 0;
  localparam int DRV_MEM = 1;
  localparam int DRV_ALU = 2;
  localparam int DRV_IMM = 3;

  typedef enum logic [2:0] {
    RS_FLD1 = 3'd0,
    RS_FLD2 = 3'd1,
    RS_FLD3 = 3'd2,
    RS_LINK = 3'd3,
    RS_PC   = 3'd4
  } rsel_e;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_SLT  = 3'd5,
    OP_INC4 = 3'd6,
    OP_PASB = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    EX_S16  = 2'd0,
    EX_Z16  = 2'd1,
    EX_S26  = 2'd2,
    EX_NONE = 2'd3
  } ext_e;

  typedef struct packed {
    logic    ld_ir;
    logic    ld_a;
    logic    ld_b;
    logic    ld_ma;
    logic    reg_we;
    logic    mem_we;
    logic    rf_oe;
    logic    mem_oe;
    logic    alu_oe;
    logic    imm_oe;
    logic [2:0] rsel;
    logic [2:0] alu_op;
    logic [1:0] ext;
  } ctl_t;

  function automatic logic [XLEN-1:0] alu_eval(input logic [2:0] op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_SLT:  r = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
      OP_INC4: r = a + XLEN'(4);
      default: r = b;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] imm_eval(input logic [1:0] mode,
                                               input logic [XLEN-1:0] ir);
    logic [XLEN-1:0] r;
    case (mode)
      EX_S16:  r = {{(XLEN-16){ir[15]}}, ir[15:0]};
      EX_Z16:  r = {{(XLEN-16){1'b0}}, ir[15:0]};
      EX_S26:  r = {{(XLEN-26){ir[25]}}, ir[25:0]};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sbd_regfile.sv
module sbd_regfile
  import sbd_pkg::*;
#(
  parameter int NREG = 32,
  localparam int NENT = NREG + 1,
  localparam int AW   = $clog2(NENT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata
);

  logic [XLEN-1:0] entry [NENT];

  assign entry[0] = '0;

  for (genvar i = 1; i < NENT; i++) begin : g_ent
    logic [XLEN-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                    q <= '0;
      else if (we && addr == AW'(i)) q <= wdata;
    end
    assign entry[i] = q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NENT; i++)
      if (addr == AW'(i)) rdata = entry[i];
  end

  // a write into the PC slot is visible there one cycle later
  AST_PC_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == AW'(NREG)) |=> (entry[NREG] == $past(wdata))); // R3

endmodule

// File: rtl/sbd_busmux.sv
module sbd_busmux
  import sbd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDRV-1:0] oe,
  input  logic [XLEN-1:0] src [NDRV],
  output logic [XLEN-1:0] bus
);

  // walk from the highest index down so the lowest enabled index wins
  always_comb begin
    bus = '0;
    for (int i = NDRV - 1; i >= 0; i--)
      if (oe[i]) bus = src[i];
  end

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oe) <= 1); // R2

endmodule

// File: rtl/sbd_alu.sv
module sbd_alu
  import sbd_pkg::*;
(
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  assign y = alu_eval(op, a, b);

endmodule

// File: rtl/sbd_immext.sv
module sbd_immext
  import sbd_pkg::*;
(
  input  logic [1:0]      mode,
  input  logic [XLEN-1:0] ir,
  output logic [XLEN-1:0] y
);

  assign y = imm_eval(mode, ir);

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbd_pkg::*;
#(
  parameter int NREG = 32,
  localparam int AW   = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CTLW-1:0] ctl_i,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_busy_i,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  output logic            mem_we_o,
  output logic            mem_re_o,
  output logic            zero_o,
  output logic [OPW-1:0]  opcode_o,
  output logic            busy_o
);

  ctl_t c;
  assign c = ctl_t'(ctl_i);

  logic [XLEN-1:0] a_q, b_q, ma_q, ir_q;
  logic [XLEN-1:0] bus;
  logic [XLEN-1:0] rf_rdata, alu_y, imm_y;
  logic [AW-1:0]   rf_addr;
  logic [XLEN-1:0] src [NDRV];
  logic [NDRV-1:0] oe;

  // register selector
  always_comb begin
    case (c.rsel)
      RS_FLD1: rf_addr = AW'(ir_q[25:21]);
      RS_FLD2: rf_addr = AW'(ir_q[20:16]);
      RS_FLD3: rf_addr = AW'(ir_q[15:11]);
      RS_LINK: rf_addr = AW'(NREG - 1);
      RS_PC:   rf_addr = AW'(NREG);
      default: rf_addr = '0;
    endcase
  end

  sbd_regfile #(.NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (rf_addr),
    .we    (c.reg_we),
    .wdata (bus),
    .rdata (rf_rdata)
  );

  sbd_alu u_alu (
    .op (c.alu_op),
    .a  (a_q),
    .b  (b_q),
    .y  (alu_y)
  );

  sbd_immext u_ext (
    .mode (c.ext),
    .ir   (ir_q),
    .y    (imm_y)
  );

  assign src[DRV_RF]  = rf_rdata;
  assign src[DRV_MEM] = mem_rdata_i;
  assign src[DRV_ALU] = alu_y;
  assign src[DRV_IMM] = imm_y;
  assign oe = {c.imm_oe, c.alu_oe, c.mem_oe, c.rf_oe};

  sbd_busmux u_bus (
    .clk   (clk),
    .rst_n (rst_n),
    .oe    (oe),
    .src   (src),
    .bus   (bus)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
      ir_q <= '0;
    end else begin
      if (c.ld_a)  a_q  <= bus;
      if (c.ld_b)  b_q  <= bus;
      if (c.ld_ma) ma_q <= bus;
      if (c.ld_ir) ir_q <= bus;
    end
  end

  assign mem_addr_o  = ma_q;
  assign mem_wdata_o = bus;
  assign mem_we_o    = c.mem_we;
  assign mem_re_o    = c.mem_oe;
  assign zero_o      = (a_q == '0);
  assign opcode_o    = ir_q[XLEN-1 -: OPW];
  assign busy_o      = mem_busy_i;

  AST_A_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    c.ld_a |=> (a_q == $past(bus))); // R5
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !c.ld_ir |=> $stable(opcode_o)); // R5
  AST_MA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    c.ld_ma |=> (mem_addr_o == $past(bus))); // R5
  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (oe == 4'b0001 && rf_addr == '0) |-> (mem_wdata_o == '0)); // R4
  AST_ZERO_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (c.ld_a && bus == '0) |=> zero_o); // R8
  AST_NONZERO_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (c.ld_a && bus != '0) |=> !zero_o); // R8

endmodule

// File: tb/sim_sbus_datapath.sv
module sim_sbus_datapath;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] ctl;
  logic [31:0] mem_rdata;
  logic        mem_busy;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_we, mem_re, zero, busy;
  logic [5:0]  opcode;

  always #5 clk = ~clk;

  sbus_datapath u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_i       (ctl),
    .mem_rdata_i (mem_rdata),
    .mem_busy_i  (mem_busy),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_we_o    (mem_we),
    .mem_re_o    (mem_re),
    .zero_o      (zero),
    .opcode_o    (opcode),
    .busy_o      (busy)
  );

  // word-addressed memory model owned by the bench
  logic [31:0] mem [64];
  assign mem_rdata = mem[mem_addr[5:0]];

  // reference state
  logic [31:0] m_reg [33];
  logic [31:0] m_a, m_b, m_ma, m_ir;
  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ref_idx(input logic [2:0] rs, input logic [31:0] ir);
    if (rs == 3'd0) return int'(ir[25:21]);
    if (rs == 3'd1) return int'(ir[20:16]);
    if (rs == 3'd2) return int'(ir[15:11]);
    if (rs == 3'd3) return 31;
    if (rs == 3'd4) return 32;
    return 0;
  endfunction

  function automatic logic [31:0] ref_alu(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
    logic [32:0] d;
    case (op)
      3'd0: return a + b;
      3'd1: return a + ~b + 32'd1;
      3'd2: return ~(~a | ~b);
      3'd3: return ~(~a & ~b);
      3'd4: return (a | b) & ~(a & b);
      3'd5: begin
        if (a[31] != b[31]) return {31'd0, a[31]};
        d = {1'b0, a} - {1'b0, b};
        return {31'd0, d[32]};
      end
      3'd6: return a + 32'd4;
      default: return b;
    endcase
  endfunction

  function automatic logic [31:0] ref_ext(input logic [1:0] m, input logic [31:0] ir);
    logic signed [31:0] s;
    case (m)
      2'd0: begin s = {ir[15:0], 16'd0}; return 32'(s >>> 16); end
      2'd1: return ir & 32'h0000_ffff;
      2'd2: begin s = {ir[25:0], 6'd0}; return 32'(s >>> 6); end
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_bus(input logic [17:0] c);
    int i;
    if (c[11]) begin
      i = ref_idx(c[7:5], m_ir);
      return (i == 0) ? 32'd0 : m_reg[i];
    end
    if (c[10]) return mem[m_ma[5:0]];
    if (c[9])  return ref_alu(c[4:2], m_a, m_b);
    if (c[8])  return ref_ext(c[1:0], m_ir);
    return 32'd0;
  endfunction

  // drv: 0 regfile, 1 memory, 2 alu, 3 extender, other none
  function automatic logic [17:0] mk(input logic [3:0] lds, input logic rwe, input logic mwe,
                                     input int drv, input logic [2:0] rs,
                                     input logic [2:0] op, input logic [1:0] ex);
    logic [17:0] c;
    c = '0;
    c[17:14] = lds;
    c[13] = rwe;
    c[12] = mwe;
    if (drv >= 0 && drv <= 3) c[11 - drv] = 1'b1;
    c[7:5] = rs;
    c[4:2] = op;
    c[1:0] = ex;
    return c;
  endfunction

  task automatic step(input logic [17:0] c, input string tag);
    logic [31:0] eb;
    int i;
    @(negedge clk);
    ctl = c;
    mem_busy = 1'($urandom_range(0, 1));
    #1;
    chk({tag, " R5 mem_addr"}, mem_addr, m_ma);
    chk({tag, " R5 opcode"}, {26'd0, opcode}, {26'd0, m_ir[31:26]});
    chk({tag, " R8 zero"}, {31'd0, zero}, {31'd0, m_a == 32'd0});
    chk({tag, " R9 busy"}, {31'd0, busy}, {31'd0, mem_busy});
    chk({tag, " R9 strobes"}, {30'd0, mem_we, mem_re}, {30'd0, c[12], c[10]});
    eb = exp_bus(c);
    chk({tag, " R1 bus"}, mem_wdata, eb);
    @(posedge clk);
    #1;
    i = ref_idx(c[7:5], m_ir);
    if (c[13] && i != 0) m_reg[i] = eb;
    if (c[12]) mem[m_ma[5:0]] = eb;
    if (c[17]) m_ir = eb;
    if (c[16]) m_a = eb;
    if (c[15]) m_b = eb;
    if (c[14]) m_ma = eb;
  endtask

  task automatic load_from_mem(input logic [3:0] lds, input logic [31:0] v, input string tag);
    mem[m_ma[5:0]] = v;
    step(mk(lds, 1'b0, 1'b0, 1, 3'd0, 3'd0, 2'd0), tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 64; k++) mem[k] = $urandom();
    for (int k = 0; k < 33; k++) m_reg[k] = 32'd0;
    m_a = '0; m_b = '0; m_ma = '0; m_ir = '0;
    ctl = '0;
    mem_busy = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10: reset state
    @(negedge clk);
    #1;
    chk("R10 reset zero", {31'd0, zero}, 32'd1);
    chk("R10 reset opcode", {26'd0, opcode}, 32'd0);
    chk("R10 reset mem_addr", mem_addr, 32'd0);
    step(mk(4'b0000, 1'b0, 1'b0, 0, 3'd4, 3'd0, 2'd0), "R10 pc slot");

    // R6/R3: fetch sequence, PC increments by 4
    step(mk(4'b0001, 1'b0, 1'b0, 0, 3'd4, 3'd0, 2'd0), "R3 fetch ma<-pc");
    step(mk(4'b1000, 1'b0, 1'b0, 1, 3'd0, 3'd0, 2'd0), "R2 fetch ir<-mem");
    step(mk(4'b0100, 1'b0, 1'b0, 0, 3'd4, 3'd0, 2'd0), "R3 fetch a<-pc");
    step(mk(4'b0000, 1'b1, 1'b0, 2, 3'd4, 3'd6, 2'd0), "R6 fetch pc<-a+4");
    step(mk(4'b0000, 1'b0, 1'b0, 0, 3'd4, 3'd0, 2'd0), "R6 pc read");
    chk("R6 pc is 4", m_reg[32], 32'd4);

    // R4: register 0 through codes 5..7
    for (int rs = 5; rs < 8; rs++) begin
      step(mk(4'b0000, 1'b1, 1'b0, 1, 3'(rs), 3'd0, 2'd0), "R4 write r0");
      step(mk(4'b0000, 1'b0, 1'b0, 0, 3'(rs), 3'd0, 2'd0), "R4 read r0");
    end
    // R3: link register write and read back
    step(mk(4'b0000, 1'b1, 1'b0, 1, 3'd3, 3'd0, 2'd0), "R3 write link");
    step(mk(4'b0000, 1'b0, 1'b0, 0, 3'd3, 3'd0, 2'd0), "R3 read link");

    // R7: extender modes on a word with both sign bits set
    load_from_mem(4'b1000, 32'h02ab_8001, "R7 load ir");
    for (int m = 0; m < 4; m++)
      step(mk(4'b0000, 1'b0, 1'b0, 3, 3'd0, 3'd0, 2'(m)), "R7 ext");
    chk("R7 sext16", ref_ext(2'd0, m_ir), 32'hffff_8001);
    chk("R7 sext26", ref_ext(2'd2, m_ir), 32'hfeab_8001);

    // R8: zero flag
    step(mk(4'b0100, 1'b0, 1'b0, 0, 3'd5, 3'd0, 2'd0), "R8 a<-r0");
    load_from_mem(4'b0100, 32'h0000_0100, "R8 a nonzero");
    step(mk(4'b0000, 1'b0, 1'b0, 4, 3'd0, 3'd0, 2'd0), "R8 idle");

    // R6: all ALU operations, signed corner and equal operands
    load_from_mem(4'b0100, 32'h8000_0000, "R6 a neg");
    load_from_mem(4'b0010, 32'h0000_0005, "R6 b pos");
    for (int op = 0; op < 8; op++)
      step(mk(4'b0000, 1'b0, 1'b0, 2, 3'd0, 3'(op), 2'd0), "R6 alu");
    load_from_mem(4'b0100, 32'h0000_0005, "R6 a eq");
    for (int op = 0; op < 8; op++)
      step(mk(4'b0000, 1'b0, 1'b0, 2, 3'd0, 3'(op), 2'd0), "R6 alu eq");

    // R1/R2: no driver and each driver alone
    step(mk(4'b0000, 1'b0, 1'b0, 4, 3'd0, 3'd0, 2'd0), "R1 no driver");
    for (int d = 0; d < 4; d++)
      step(mk(4'b0000, 1'b0, 1'b0, d, 3'd4, 3'd0, 2'd0), "R2 single driver");

    // random transfers
    for (int n = 0; n < 3000; n++) begin
      step(mk(4'($urandom()), 1'($urandom()), 1'($urandom()),
              int'($urandom_range(0, 4)), 3'($urandom()), 3'($urandom()),
              2'($urandom())), "R3 random");
    end

    summary();
    $finish;
  end

endmodule